// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block is the control/status register of one DMA channel. The channel runs either as one unified channel or, when the split-mode bit is set, as a primary and an auxiliary sub-channel. For each sub-channel the register holds an interrupt-enable bit, a sticky completion flag and a 2-bit start code. The completion strobes come from the transfer engine. Each strobe marks the cycle in which that sub-channel's transfer counter has reached zero and the last write of the block has finished. The engine also sends start-code updates: a general update and a forced halt at the end of a counter-terminated block.

Both sub-channels share one interrupt line to the CPU. Software reads the register and looks at the two flags to learn which sub-channel caused the interrupt. Any read clears both flags, unless a flag is being set in that same cycle. All CPU access is through plain write and read strobes, with no back-pressure. A write or read completes in the cycle its strobe is high, and read data is valid in that same cycle.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, every register bit reads 0, `irq` is 0, and both start-code outputs are 00.
- R2: The register layout is as follows. Bit 0 is the primary interrupt enable and bit 1 the auxiliary interrupt enable. Bits 5:4 hold the primary start code, bits 7:6 the auxiliary start code, and bit 8 selects split mode. A CPU write loads all of these. Bits 2 and 3 are read-only, and the value written to them has no effect.
- R3: A `pri_done` strobe sets the primary flag (read bit 2) in either mode, whatever the enable. The flag is visible in the cycle after the strobe.
- R4: An `aux_done` strobe sets the auxiliary flag (read bit 3) only in split mode. In unified mode the strobe is ignored.
- R5: A CPU read returns the flag values from before the read, and both flags are 0 in the following cycle.
- R6: If a flag's set strobe falls in the same cycle as a read, that flag stays 1.
- R7: A `pri_done` strobe with the primary enable at 1 gives a one-cycle `irq` pulse in the next cycle. With the enable at 0 it gives no pulse.
- R8: In split mode, an `aux_done` strobe with the auxiliary enable at 1 gives an `irq` pulse on the same shared line. At no other time is `irq` high.
- R9: An internal start-code update overrides a CPU write to that field in the same cycle. The other fields still take the CPU write.
- R10: A counter-terminated halt strobe forces that start code to 10. It overrides both the general update and a CPU write.
- R11: In unified mode, `aux_start_code` is 00 and the auxiliary internal updates and halts are ignored. The stored auxiliary field still follows CPU writes.
- R12: The start codes are 00 abort, 01 hold after the current transfer, 10 halt after the block, and 11 run. `pri_start_code` always shows the stored primary field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_data | input | 9 | CPU write data |
| cpu_rd_en | input | 1 | CPU register read strobe (clears the flags) |
| cpu_rd_data | output | 9 | Register contents, valid in the same cycle |
| pri_done | input | 1 | Primary counter at zero and last write done |
| aux_done | input | 1 | Auxiliary counter at zero and last write done |
| pri_start_upd | input | 1 | Engine updates the primary start code |
| pri_start_upd_code | input | 2 | Value for the primary update |
| aux_start_upd | input | 1 | Engine updates the auxiliary start code |
| aux_start_upd_code | input | 2 | Value for the auxiliary update |
| pri_tc_halt | input | 1 | Force the primary start code to halt (10) |
| aux_tc_halt | input | 1 | Force the auxiliary start code to halt (10) |
| irq | output | 1 | Shared single-cycle channel interrupt |
| pri_start_code | output | 2 | Primary start code to the engine |
| aux_start_code | output | 2 | Auxiliary start code to the engine (00 when unified) |

## Verification
Two pairs of functions can fall in the same cycle. A flag can be set while software reads and clears the register. A start field can be written by the CPU while the engine updates or force-halts it. The bench provokes each pair by raising the strobes together. A set that collides with a read must leave the flag at 1, while the other flag still clears. The engine's value (a halt ahead of an update) must land in the start field, while the enable and mode bits take the CPU data.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int NSUB     = 2;
  localparam int CODE_W   = 2;
  localparam int CSR_W    = 9;
  localparam int IE_LSB   = 0;
  localparam int FLAG_LSB = 2;
  localparam int CODE_LSB = 4;
  localparam int SPLIT_B  = CODE_LSB + NSUB * CODE_W;

  typedef enum logic [CODE_W-1:0] {
    START_ABORT = 2'b00,
    START_HOLD  = 2'b01,
    START_HALT  = 2'b10,
    START_RUN   = 2'b11
  } start_code_e;
endpackage

// File: rtl/dcsr_flag.sv
module dcsr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // a set in the same cycle as a clearing read wins
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dcsr_start_fld.sv
module dcsr_start_fld
  import dcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_en_i,
  input  logic              cpu_we_i,
  input  logic [CODE_W-1:0] cpu_val_i,
  input  logic              upd_i,
  input  logic [CODE_W-1:0] upd_val_i,
  input  logic              halt_i,
  output logic [CODE_W-1:0] code_o
);
  start_code_e code_q, code_d;

  // priority: forced halt, then engine update, then CPU write
  always_comb begin
    code_d = code_q;
    if (int_en_i && halt_i)     code_d = START_HALT;
    else if (int_en_i && upd_i) code_d = start_code_e'(upd_val_i);
    else if (cpu_we_i)          code_d = start_code_e'(cpu_val_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= START_ABORT;
    else        code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/dcsr_irq_gen.sv
module dcsr_irq_gen #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(evt_i & en_i);
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [CSR_W-1:0]  cpu_wr_data,
  input  logic              cpu_rd_en,
  output logic [CSR_W-1:0]  cpu_rd_data,
  input  logic              pri_done,
  input  logic              aux_done,
  input  logic              pri_start_upd,
  input  logic [CODE_W-1:0] pri_start_upd_code,
  input  logic              aux_start_upd,
  input  logic [CODE_W-1:0] aux_start_upd_code,
  input  logic              pri_tc_halt,
  input  logic              aux_tc_halt,
  output logic              irq,
  output logic [CODE_W-1:0] pri_start_code,
  output logic [CODE_W-1:0] aux_start_code
);
  logic              split_q;
  logic [NSUB-1:0]   ie_q;
  logic [NSUB-1:0]   flag_v;
  logic [NSUB-1:0]   active;
  logic [NSUB-1:0]   done_v;
  logic [NSUB-1:0]   upd_v;
  logic [NSUB-1:0]   halt_v;
  logic [CODE_W-1:0] upd_code_v [NSUB];
  logic [CODE_W-1:0] code_v     [NSUB];
  logic [NSUB-1:0]   evt_v;

  // index 0 is the primary (also the unified channel), index 1 the auxiliary
  assign active        = {split_q, 1'b1};
  assign done_v        = {aux_done, pri_done};
  assign upd_v         = {aux_start_upd, pri_start_upd};
  assign halt_v        = {aux_tc_halt, pri_tc_halt};
  assign upd_code_v[0] = pri_start_upd_code;
  assign upd_code_v[1] = aux_start_upd_code;
  assign evt_v         = done_v & active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q    <= '0;
      split_q <= 1'b0;
    end else if (cpu_wr_en) begin
      ie_q    <= cpu_wr_data[IE_LSB +: NSUB];
      split_q <= cpu_wr_data[SPLIT_B];
    end
  end

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    localparam int CLSB = CODE_LSB + g * CODE_W;

    dcsr_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_v[g]),
      .clr_i  (cpu_rd_en),
      .flag_o (flag_v[g])
    );

    dcsr_start_fld u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .int_en_i  (active[g]),
      .cpu_we_i  (cpu_wr_en),
      .cpu_val_i (cpu_wr_data[CLSB +: CODE_W]),
      .upd_i     (upd_v[g]),
      .upd_val_i (upd_code_v[g]),
      .halt_i    (halt_v[g]),
      .code_o    (code_v[g])
    );

    assign cpu_rd_data[IE_LSB + g]       = ie_q[g];
    assign cpu_rd_data[FLAG_LSB + g]     = flag_v[g];
    assign cpu_rd_data[CLSB +: CODE_W]   = code_v[g];
  end

  assign cpu_rd_data[SPLIT_B] = split_q;

  dcsr_irq_gen #(.N_SRC(NSUB)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_v),
    .en_i  (ie_q),
    .irq_o (irq)
  );

  assign pri_start_code = code_v[0];
  assign aux_start_code = split_q ? code_v[1] : START_ABORT;
endmodule

// File: rtl/dcsr_chk.sv
module dcsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr_en,
  input logic       cpu_rd_en,
  input logic [8:0] cpu_rd_data,
  input logic       pri_done,
  input logic       aux_done,
  input logic       pri_start_upd,
  input logic [1:0] pri_start_upd_code,
  input logic       pri_tc_halt,
  input logic       irq,
  input logic [1:0] aux_start_code
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (cpu_rd_data == 9'h000 && !irq));

  a_r3_pri_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    pri_done |=> cpu_rd_data[2]);

  a_r4_aux_unified_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd_data[8] && !cpu_rd_data[3]) |=> !cpu_rd_data[3]);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && !pri_done) |=> !cpu_rd_data[2]);

  a_r7_pri_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_done && cpu_rd_data[0]) |=> irq);

  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((pri_done && cpu_rd_data[0]) ||
                  (aux_done && cpu_rd_data[1] && cpu_rd_data[8])));

  a_r9_update_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && pri_start_upd && !pri_tc_halt) |=>
      (cpu_rd_data[5:4] == $past(pri_start_upd_code)));

  a_r10_halt_forced: assert property (@(posedge clk) disable iff (!rst_n)
    pri_tc_halt |=> (cpu_rd_data[5:4] == 2'b10));

  a_r11_aux_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_data[8] |-> (aux_start_code == 2'b00));
endmodule

bind dma_chan_csr dcsr_chk i_dcsr_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .cpu_wr_en          (cpu_wr_en),
  .cpu_rd_en          (cpu_rd_en),
  .cpu_rd_data        (cpu_rd_data),
  .pri_done           (pri_done),
  .aux_done           (aux_done),
  .pri_start_upd      (pri_start_upd),
  .pri_start_upd_code (pri_start_upd_code),
  .pri_tc_halt        (pri_tc_halt),
  .irq                (irq),
  .aux_start_code     (aux_start_code)
);

// File: tb/test_dma_chan_csr.sv
module test_dma_chan_csr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr_en = 1'b0;
  logic [8:0] cpu_wr_data = '0;
  logic       cpu_rd_en = 1'b0;
  logic [8:0] cpu_rd_data;
  logic       pri_done = 1'b0;
  logic       aux_done = 1'b0;
  logic       pri_start_upd = 1'b0;
  logic [1:0] pri_start_upd_code = '0;
  logic       aux_start_upd = 1'b0;
  logic [1:0] aux_start_upd_code = '0;
  logic       pri_tc_halt = 1'b0;
  logic       aux_tc_halt = 1'b0;
  logic       irq;
  logic [1:0] pri_start_code;
  logic [1:0] aux_start_code;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_chan_csr i_dma_chan_csr (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [8:0] d);
    cpu_wr_en = 1'b1; cpu_wr_data = d;
    tick();
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd_clear();
    cpu_rd_en = 1'b1;
    tick();
    cpu_rd_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reg", 16'(cpu_rd_data), 16'h000);
    check("R1 irq", 16'(irq), 16'h0);
    check("R1 codes", {12'h0, pri_start_code, aux_start_code}, 16'h0);
  endtask

  task automatic t_layout();
    wr(9'h1FF);
    check("R2 all ones, flags read-only", 16'(cpu_rd_data), 16'h1F3);
    check("R12 run code out", 16'(pri_start_code), 16'h3);
    check("R11 split aux out", 16'(aux_start_code), 16'h3);
    wr(9'h0B6);
    check("R2 mixed pattern", 16'(cpu_rd_data), 16'h0B2);
    check("R11 unified aux out idle", 16'(aux_start_code), 16'h0);
    check("R12 pri out follows field", 16'(pri_start_code), 16'h3);
    wr(9'h000);
  endtask

  task automatic t_pri_irq();
    wr(9'h001);
    pri_done = 1'b1;
    tick();
    pri_done = 1'b0;
    check("R7 pulse", 16'(irq), 16'h1);
    check("R3 flag set", 16'(cpu_rd_data[2]), 16'h1);
    tick();
    check("R7 one cycle", 16'(irq), 16'h0);
    cpu_rd_en = 1'b1;
    #1;
    check("R5 read shows pre-clear flag", 16'(cpu_rd_data[2]), 16'h1);
    tick();
    cpu_rd_en = 1'b0;
    check("R5 flag cleared", 16'(cpu_rd_data[2]), 16'h0);
    wr(9'h000);
    pri_done = 1'b1;
    tick();
    pri_done = 1'b0;
    check("R7 disabled no pulse", 16'(irq), 16'h0);
    check("R3 flag set while disabled", 16'(cpu_rd_data[2]), 16'h1);
    rd_clear();
  endtask

  task automatic t_read_collide();
    wr(9'h100);
    aux_done = 1'b1;
    tick();
    aux_done = 1'b0;
    check("R4 aux flag set in split", 16'(cpu_rd_data[3]), 16'h1);
    cpu_rd_en = 1'b1; pri_done = 1'b1;
    tick();
    cpu_rd_en = 1'b0; pri_done = 1'b0;
    check("R6 set wins over read", 16'(cpu_rd_data[2]), 16'h1);
    check("R5 other flag cleared", 16'(cpu_rd_data[3]), 16'h0);
    check("R7 no pulse, enables off", 16'(irq), 16'h0);
    rd_clear();
  endtask

  task automatic t_aux();
    wr(9'h0C2);
    check("R11 aux field stored, out idle", {12'h0, cpu_rd_data[7:6], aux_start_code}, 16'hC);
    aux_done = 1'b1;
    tick();
    aux_done = 1'b0;
    check("R4 unified ignores aux irq", 16'(irq), 16'h0);
    check("R4 unified ignores aux flag", 16'(cpu_rd_data[3]), 16'h0);
    wr(9'h1C2);
    check("R11 split aux out", 16'(aux_start_code), 16'h3);
    aux_done = 1'b1;
    tick();
    aux_done = 1'b0;
    check("R8 aux pulse on shared line", 16'(irq), 16'h1);
    check("R8 flags tell source", 16'(cpu_rd_data[3:2]), 16'h2);
    rd_clear();
    wr(9'h000);
  endtask

  task automatic t_start_prio();
    cpu_wr_en = 1'b1; cpu_wr_data = 9'h031;
    pri_start_upd = 1'b1; pri_start_upd_code = 2'b01;
    tick();
    cpu_wr_en = 1'b0; pri_start_upd = 1'b0;
    check("R9 update beats write", 16'(pri_start_code), 16'h1);
    check("R9 other fields take write", 16'(cpu_rd_data[0]), 16'h1);
    wr(9'h040);
    aux_start_upd = 1'b1; aux_start_upd_code = 2'b11;
    tick();
    aux_start_upd = 1'b0;
    check("R11 unified aux update ignored", 16'(cpu_rd_data[7:6]), 16'h1);
    aux_tc_halt = 1'b1;
    tick();
    aux_tc_halt = 1'b0;
    check("R11 unified aux halt ignored", 16'(cpu_rd_data[7:6]), 16'h1);
  endtask

  task automatic t_halt();
    wr(9'h130);
    cpu_wr_en = 1'b1; cpu_wr_data = 9'h1F0;
    pri_tc_halt = 1'b1; aux_tc_halt = 1'b1;
    pri_start_upd = 1'b1; pri_start_upd_code = 2'b11;
    tick();
    cpu_wr_en = 1'b0; pri_tc_halt = 1'b0; aux_tc_halt = 1'b0; pri_start_upd = 1'b0;
    check("R10 primary halt code", 16'(pri_start_code), 16'h2);
    check("R10 aux halt code in split", 16'(aux_start_code), 16'h2);
    check("R10 register view", 16'(cpu_rd_data), 16'h1A0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_layout();
    t_pri_irq();
    t_read_collide();
    t_aux();
    t_start_prio();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule